// File: doc/BRIEF.md
# Glitch-Free Output Clock Stop/Start Gate

This block sits between a set of free-running source clocks and the output stage of a clock generator. Each output can be halted and resumed on its own while every other output, and the rest of the generator, keeps running. An output runs only while its external enable pin and its control-register enable bit are both high. Dropping either one stops it.

Stops and starts happen only on whole source-clock cycles. A stopped output rests at logic 0. The first pulse after a restart, and the last pulse before a stop, are exactly one source high phase wide. The enable pin is asynchronous, so the pin/bit combination passes through a flop chain clocked by that output's own source clock.

A small state machine then decides when the gate may open. It has three states:
- STOPPED: the output is held low.
- WARMUP: one settling cycle.
- RUNNING: the output follows the source clock.

The transitions are:
- STOPPED to WARMUP when the synchronised enable is high.
- WARMUP to RUNNING when the enable is still high.
- WARMUP back to STOPPED when the enable has fallen.
- RUNNING to STOPPED when the enable falls.

The gate itself is a falling-edge flop ANDed with the source clock, so the gate control only changes while the clock is low.

Top module: `clkout_gate_bank`

## Requirements
- R1: While `rst_n` is low, every `clk_out` bit is 0.
- R2: With `pin_en[i]` and `reg_en[i]` both 1, `clk_out[i]` is high during every high phase of `clk_src[i]`.
- R3: When `pin_en[i]` falls while running, `clk_out[i]` still gives exactly three pulses, starting on source rising edges 1, 2 and 3 after the change (the first rising edge after the change is edge 1). After that it gives none.
- R4: When `reg_en[i]` falls while running, the stop behaves exactly as in R3: three more pulses, then none.
- R5: If either enable is 0, a stopped output stays stopped whatever the other enable does.
- R6: When the AND of the two enables rises on a stopped output, the first output pulse begins on source rising edge SYNC_STAGES+3 after the change. This is edge 5 with two stages, four cycles after the first sampling edge and so within 2 to 6 cycles.
- R7: Every high pulse on `clk_out[i]` lasts exactly one high phase of `clk_src[i]`. There are no runt or stretched pulses.
- R8: A stopped output stays at 0 through every source high phase.
- R9: Stopping one output leaves every other output running on all of its cycles.
- R10: An enable that is high for only one source cycle, on a stopped output, produces no output pulse, and the output stays stopped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset for all outputs |
| clk_src | input | NUM_OUT | Free-running source clock per output |
| pin_en | input | NUM_OUT | Asynchronous active-high enable pin per output |
| reg_en | input | NUM_OUT | Register enable bit per output, active high |
| clk_out | output | NUM_OUT | Gated output clocks, low when stopped |

## Verification
The bench builds the block with NUM_OUT=3 and SYNC_STAGES=2, and drives the three sources at unrelated periods of 20 ns, 16 ns and 28 ns. The unrelated periods let the bench check R9: one output's stop must not disturb outputs whose edges never line up with it. With two stages, the restart edge (5) and the stop pulse count (3) take exact values that the bench compares per output. A width monitor on every output compares each high pulse with its own source half-period.

// File: rtl/clkgate_pkg.sv
package clkgate_pkg;
    typedef enum logic [1:0] {
        GS_STOPPED = 2'd0,
        GS_WARMUP  = 2'd1,
        GS_RUNNING = 2'd2
    } gate_state_e;
endpackage

// File: rtl/clkgate_sync.sv
module clkgate_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/clkgate_ctrl.sv
module clkgate_ctrl
    import clkgate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic run_o
);
    gate_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_STOPPED: if (en_i) state_d = GS_WARMUP;
            GS_WARMUP:  state_d = en_i ? GS_RUNNING : GS_STOPPED;
            GS_RUNNING: if (!en_i) state_d = GS_STOPPED;
            default:    state_d = GS_STOPPED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GS_STOPPED;
        else        state_q <= state_d;
    end

    always_comb begin
        run_o = (state_q == GS_RUNNING);
    end

    // R6
    warmup_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_WARMUP) |=> (state_q != GS_WARMUP));

    // R10
    run_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == GS_RUNNING) |->
        ($past(state_q) == GS_WARMUP || $past(state_q) == GS_RUNNING));
endmodule

// File: rtl/clkgate_cell.sv
module clkgate_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic clk_o
);
    logic gate_q;

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) gate_q <= 1'b0;
        else        gate_q <= run_i;
    end

    assign clk_o = clk & gate_q;

    // R8
    stopped_low_chk: assert property (@(negedge clk) disable iff (!rst_n)
        !$past(run_i) |-> !clk_o);

    // R2
    running_high_chk: assert property (@(negedge clk) disable iff (!rst_n)
        $past(run_i) |-> clk_o);
endmodule

// File: rtl/clkout_gate_bank.sv
module clkout_gate_bank #(
    parameter int NUM_OUT     = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic               rst_n,
    input  logic [NUM_OUT-1:0] clk_src,
    input  logic [NUM_OUT-1:0] pin_en,
    input  logic [NUM_OUT-1:0] reg_en,
    output logic [NUM_OUT-1:0] clk_out
);
    localparam int LAST = NUM_OUT - 1;

    logic [LAST:0] en_raw;
    logic [LAST:0] en_sync;
    logic [LAST:0] run;

    for (genvar i = 0; i < NUM_OUT; i++) begin : g_out
        assign en_raw[i] = pin_en[i] & reg_en[i];

        clkgate_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk_src[i]),
            .rst_n (rst_n),
            .d_i   (en_raw[i]),
            .q_o   (en_sync[i])
        );

        clkgate_ctrl u_ctrl (
            .clk   (clk_src[i]),
            .rst_n (rst_n),
            .en_i  (en_sync[i]),
            .run_o (run[i])
        );

        clkgate_cell u_cell (
            .clk   (clk_src[i]),
            .rst_n (rst_n),
            .run_i (run[i]),
            .clk_o (clk_out[i])
        );
    end
endmodule

// File: tb/clkout_gate_bank_tb.sv
`timescale 1ns/1ps
module clkout_gate_bank_tb;
    localparam int N = 3;
    localparam int SYNC = 2;
    localparam realtime HALF0 = 10.0;
    localparam realtime HALF1 = 8.0;
    localparam realtime HALF2 = 14.0;

    typedef struct {
        int    idx;
        int    kind;   // 0: start edge, 1: pulses after stop, 2: pulses while blocked
        int    val;
        string req;
    } exp_t;

    logic clk_a, clk_b, clk_c;
    logic rst_n;
    logic [N-1:0] clk_src, pin_en, reg_en, clk_out;
    int checks, fails;
    exp_t sb_q[$];

    assign clk_src = {clk_c, clk_b, clk_a};

    clkout_gate_bank #(.NUM_OUT(N), .SYNC_STAGES(SYNC)) u_dut (
        .rst_n(rst_n), .clk_src(clk_src), .pin_en(pin_en),
        .reg_en(reg_en), .clk_out(clk_out)
    );

    initial begin clk_a = 0; forever #(HALF0) clk_a = ~clk_a; end
    initial begin clk_b = 0; forever #(HALF1) clk_b = ~clk_b; end
    initial begin clk_c = 0; forever #(HALF2) clk_c = ~clk_c; end

    function automatic realtime half_of(int k);
        return (k == 0) ? HALF0 : (k == 1) ? HALF1 : HALF2;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // R7: pulse-width monitor on every output
    for (genvar g = 0; g < N; g++) begin : g_mon
        realtime t_rise;
        always @(posedge clk_out[g]) t_rise = $realtime;
        always @(negedge clk_out[g]) begin
            if (rst_n) begin
                realtime w;
                w = $realtime - t_rise;
                chk((w > half_of(g) - 0.001) && (w < half_of(g) + 0.001), "R7",
                    $sformatf("pulse width ps on out%0d", g),
                    int'(w * 1000.0), int'(half_of(g) * 1000.0));
            end
        end
    end

    // sample the output during the high phase that follows a source rising edge
    task automatic sample_high(int k, output logic v);
        @(posedge clk_src[k]);
        #1;
        v = clk_out[k];
    endtask

    // driver: push expectation, then apply the inputs just after a falling edge
    task automatic drive(int k, logic p, logic r, int kind, int val, string req);
        exp_t e;
        e.idx = k; e.kind = kind; e.val = val; e.req = req;
        sb_q.push_back(e);
        @(negedge clk_src[k]);
        #1;
        pin_en[k] = p;
        reg_en[k] = r;
    endtask

    // monitor: pop expectation and measure the output
    task automatic observe();
        exp_t e;
        logic v;
        int meas;
        e = sb_q.pop_front();
        meas = 0;
        if (e.kind == 0) begin
            meas = 99;
            for (int n = 1; n <= 12; n++) begin
                sample_high(e.idx, v);
                if (v && meas == 99) meas = n;
            end
            chk(meas == e.val, e.req, $sformatf("restart edge out%0d", e.idx), meas, e.val);
        end else begin
            for (int n = 1; n <= 12; n++) begin
                sample_high(e.idx, v);
                if (v) meas++;
            end
            chk(meas == e.val, e.req, $sformatf("pulse count out%0d", e.idx), meas, e.val);
            chk(v == 1'b0, "R8", $sformatf("resting level out%0d", e.idx), int'(v), 0);
        end
    endtask

    // R10: one-cycle enable blip on a stopped output
    task automatic blip(int k);
        exp_t e;
        logic v;
        int meas;
        e.idx = k; e.kind = 2; e.val = 0; e.req = "R10";
        sb_q.push_back(e);
        @(negedge clk_src[k]);
        #1;
        pin_en[k] = 1'b1;
        e = sb_q.pop_front();
        meas = 0;
        sample_high(k, v);
        if (v) meas++;
        @(negedge clk_src[k]);
        #1;
        pin_en[k] = 1'b0;
        for (int n = 2; n <= 12; n++) begin
            sample_high(k, v);
            if (v) meas++;
        end
        chk(meas == e.val, e.req, $sformatf("blip pulses out%0d", k), meas, e.val);
    endtask

    task automatic finish_up();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        #2000000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual 1 expected 0");
        finish_up();
    end

    initial begin
        logic v;
        int cnt;
        checks = 0; fails = 0;
        rst_n = 1'b0;
        pin_en = '1;
        reg_en = '1;
        repeat (4) @(posedge clk_a);
        // R1: outputs low under reset
        for (int k = 0; k < N; k++) begin
            sample_high(k, v);
            chk(v == 1'b0, "R1", $sformatf("reset level out%0d", k), int'(v), 0);
        end
        @(negedge clk_a);
        #1;
        rst_n = 1'b1;
        repeat (10) @(posedge clk_c);
        // R2: all running
        for (int k = 0; k < N; k++) begin
            cnt = 0;
            for (int n = 0; n < 8; n++) begin
                sample_high(k, v);
                if (v) cnt++;
            end
            chk(cnt == 8, "R2", $sformatf("running pulses out%0d", k), cnt, 8);
        end

        for (int k = 0; k < N; k++) begin
            // R3: pin stop
            drive(k, 1'b0, 1'b1, 1, 3, "R3");
            observe();
            // R8: stays low
            cnt = 0;
            for (int n = 0; n < 16; n++) begin
                sample_high(k, v);
                if (v) cnt++;
            end
            chk(cnt == 0, "R8", $sformatf("stopped highs out%0d", k), cnt, 0);
            // R9: the others keep running
            for (int j = 0; j < N; j++) begin
                if (j != k) begin
                    cnt = 0;
                    for (int n = 0; n < 6; n++) begin
                        sample_high(j, v);
                        if (v) cnt++;
                    end
                    chk(cnt == 6, "R9", $sformatf("out%0d while out%0d stopped", j, k), cnt, 6);
                end
            end
            // R5: register bit low blocks the pin
            drive(k, 1'b0, 1'b0, 2, 0, "R5");
            observe();
            drive(k, 1'b1, 1'b0, 2, 0, "R5");
            observe();
            // R6: restart by register bit
            drive(k, 1'b1, 1'b1, 0, SYNC + 3, "R6");
            observe();
            // R4: register stop
            drive(k, 1'b1, 1'b0, 1, 3, "R4");
            observe();
            // R5: pin low blocks the register bit
            drive(k, 1'b0, 1'b1, 2, 0, "R5");
            observe();
            // R10: short blip stays stopped
            blip(k);
            // R6: restart by pin
            drive(k, 1'b1, 1'b1, 0, SYNC + 3, "R6");
            observe();
        end
        repeat (4) @(posedge clk_c);
        finish_up();
    end
endmodule